// File: doc/BRIEF.md
# Opcode Bit-Rewrite Bus Snooper

The block sits between memory and the CPU data inputs. On opcode-fetch cycles it can force individual data bits, so that a rarely used instruction reaches the CPU as a different, harmless one. The bus stays bidirectional, because only the byte travelling toward the CPU is altered. After a rewrite, the block follows the bus cycles that the substitute instruction produces. From them it extracts what a coprocessor needs.

Three rewrite modes can be selected:
- **Signature mode** turns the coprocessor opcode into a two-byte no-operation. It captures the byte read in the next cycle as a signature.
- **Trigger mode** turns the stop opcode into the wait opcode. The rewrite itself is the trigger event. The block can then take the bus while the CPU holds RDY low.
- **Long-pointer mode** turns stop and wait into indirect-long compares. It captures the 24-bit pointer, the address of the target read and the byte read there.

Every capture is announced by a one-cycle valid pulse.

Top module: `opcode_rewriter`

## Requirements
- R1: Bits are rewritten only in opcode-fetch reads, where cpu_vpa=1, cpu_vda=1 and cpu_rwb=1. In every other cycle cpu_dout equals mem_din.
- R2: With mode_sel=0 nothing is rewritten. With mode_sel=1, a fetched 0x02 reaches the CPU as 0x42 (bit 6 forced to 1). In either mode, every other fetched byte passes unchanged.
- R3: After a mode 1 rewrite, the next cycle is checked. If it has cpu_vpa=1, cpu_vda=0 and cpu_rwb=1, its data byte appears on sig_byte, and sig_valid is high for the one cycle after that edge. Any other cycle type abandons the capture without a pulse.
- R4: With mode_sel=2, a fetched 0xDB reaches the CPU as 0xCB (bit 4 forced to 0). trig_valid pulses for one cycle after the fetch edge. Other bytes pass unchanged.
- R5: After a mode 2 trigger, the block waits for cpu_rdy to be sampled low. be_out then goes low on the next cycle, and stays low until cpu_rdy is sampled high. An opcode fetch that comes before cpu_rdy goes low cancels the request. With TAKE_BUS=0, be_out never goes low.
- R6: With mode_sel=3, a fetched 0xDB becomes 0xD7 and a fetched 0xCB becomes 0xC7 (bit 2 forced to 1, bit 3 forced to 0). Other bytes pass unchanged.
- R7: After a mode 3 rewrite, cycles of two kinds may come before the first pointer read: operand fetches (cpu_vpa=1, cpu_vda=0) and idle cycles (both low). Then come four data reads (cpu_vda=1, cpu_vpa=0, cpu_rwb=1):
  - The first three supply the pointer in low, high, bank order, shown on lptr_ptr.
  - The fourth supplies lptr_data, and its cpu_addr is shown on lptr_addr.
  - lptr_valid pulses for one cycle.
- R8: In mode 3, once pointer reads have begun, any cycle that is not a data read abandons the capture without lptr_valid.
- R9: An opcode fetch during a pending capture or a pending bus request restarts decoding from that fetch. A fetch that does not match the active mode returns the block to idle. This does not apply while the bus is held.
- R10: After reset, be_out=1 and every valid output and captured field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock, one rising edge per CPU cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 pass-through, 1 signature, 2 trigger, 3 long pointer |
| mem_din | input | 8 | Data byte from memory toward the CPU |
| cpu_dout | output | 8 | Possibly rewritten byte presented to the CPU |
| cpu_addr | input | 24 | CPU address including bank |
| cpu_vpa | input | 1 | Program-address valid status from the CPU |
| cpu_vda | input | 1 | Data-address valid status from the CPU |
| cpu_rwb | input | 1 | 1 for read, 0 for write |
| cpu_rdy | input | 1 | Observed RDY line (the CPU pulls it low while waiting) |
| be_out | output | 1 | Bus enable to the CPU, low while the bus is taken |
| sig_valid | output | 1 | One-cycle pulse: sig_byte updated |
| sig_byte | output | 8 | Captured signature byte |
| trig_valid | output | 1 | One-cycle pulse on a trigger-mode rewrite |
| lptr_valid | output | 1 | One-cycle pulse: long-pointer capture updated |
| lptr_ptr | output | 24 | Pointer assembled from the three pointer reads |
| lptr_addr | output | 24 | Address of the target read |
| lptr_data | output | 8 | Byte read at the target |

## Verification
The assertions take three things for granted:
- Each rising clock edge ends exactly one CPU bus cycle.
- The status lines and data are settled at that edge.
- cpu_rdy is only driven low by the CPU after a trigger-mode rewrite.

The stimulus keeps within this. It changes all inputs together at the falling edge, one complete bus cycle per clock. It pulls cpu_rdy low only inside the bus-take scenarios, after a trigger fetch. The exhaustive sweeps hold cpu_rdy high, so the pending requests they start are always cancelled by the next fetch.

// File: rtl/opcode_rewriter.sv
module opcode_rewriter #(
  parameter bit TAKE_BUS = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic [7:0]  mem_din,
  output logic [7:0]  cpu_dout,
  input  logic [23:0] cpu_addr,
  input  logic        cpu_vpa,
  input  logic        cpu_vda,
  input  logic        cpu_rwb,
  input  logic        cpu_rdy,
  output logic        be_out,
  output logic        sig_valid,
  output logic [7:0]  sig_byte,
  output logic        trig_valid,
  output logic        lptr_valid,
  output logic [23:0] lptr_ptr,
  output logic [23:0] lptr_addr,
  output logic [7:0]  lptr_data
);
  localparam logic [1:0] M_SIG  = 2'd1;
  localparam logic [1:0] M_TRIG = 2'd2;
  localparam logic [1:0] M_LONG = 2'd3;
  localparam logic [7:0] OP_COP = 8'h02;
  localparam logic [7:0] OP_STP = 8'hDB;
  localparam logic [7:0] OP_WAI = 8'hCB;

  typedef enum logic [2:0] {S_IDLE, S_SIG, S_HWAIT, S_HELD, S_PRE, S_PTR} st_t;

  st_t         st;
  logic [1:0]  pcnt;
  logic [23:0] ptr;
  logic [7:0]  rw;

  wire fetch   = cpu_vpa & cpu_vda & cpu_rwb;
  wire dread   = cpu_vda & ~cpu_vpa & cpu_rwb;
  wire operand = cpu_vpa & ~cpu_vda & cpu_rwb;
  wire hit_a   = (mode_sel == M_SIG)  && (mem_din == OP_COP);
  wire hit_b   = (mode_sel == M_TRIG) && (mem_din == OP_STP);
  wire hit_c   = (mode_sel == M_LONG) && (mem_din == OP_STP || mem_din == OP_WAI);

  always_comb begin
    rw = mem_din;
    if (fetch) begin
      if (hit_a) rw[6] = 1'b1;
      if (hit_b) rw[4] = 1'b0;
      if (hit_c) begin
        rw[2] = 1'b1;
        rw[3] = 1'b0;
      end
    end
  end
  assign cpu_dout = rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pcnt       <= 2'd0;
      ptr        <= '0;
      be_out     <= 1'b1;
      sig_valid  <= 1'b0;
      sig_byte   <= '0;
      trig_valid <= 1'b0;
      lptr_valid <= 1'b0;
      lptr_ptr   <= '0;
      lptr_addr  <= '0;
      lptr_data  <= '0;
    end else begin
      sig_valid  <= 1'b0;
      trig_valid <= 1'b0;
      lptr_valid <= 1'b0;
      if (st == S_HELD) begin
        if (cpu_rdy) begin
          be_out <= 1'b1;
          st     <= S_IDLE;
        end
      end else if (fetch) begin
        if (hit_a) st <= S_SIG;
        else if (hit_b) begin
          trig_valid <= 1'b1;
          st         <= S_HWAIT;
        end else if (hit_c) begin
          pcnt <= 2'd0;
          st   <= S_PRE;
        end else st <= S_IDLE;
      end else begin
        case (st)
          S_SIG: begin
            if (operand) begin
              sig_byte  <= mem_din;
              sig_valid <= 1'b1;
            end
            st <= S_IDLE;
          end
          S_HWAIT: begin
            if (!cpu_rdy) begin
              if (TAKE_BUS) begin
                be_out <= 1'b0;
                st     <= S_HELD;
              end else st <= S_IDLE;
            end
          end
          S_PRE: begin
            if (dread) begin
              ptr[7:0] <= mem_din;
              pcnt     <= 2'd1;
              st       <= S_PTR;
            end else if (cpu_vda || !cpu_rwb) st <= S_IDLE;
          end
          S_PTR: begin
            if (dread) begin
              pcnt <= pcnt + 2'd1;
              case (pcnt)
                2'd1: ptr[15:8]  <= mem_din;
                2'd2: ptr[23:16] <= mem_din;
                default: begin
                  lptr_ptr   <= ptr;
                  lptr_addr  <= cpu_addr;
                  lptr_data  <= mem_din;
                  lptr_valid <= 1'b1;
                  st         <= S_IDLE;
                end
              endcase
            end else st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/opcode_rewriter_checker.sv
module opcode_rewriter_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [7:0] mem_din,
  input logic [7:0] cpu_dout,
  input logic       cpu_vpa,
  input logic       cpu_vda,
  input logic       cpu_rwb,
  input logic       cpu_rdy,
  input logic       be_out,
  input logic       sig_valid,
  input logic       trig_valid,
  input logic       lptr_valid
);
  AST_NONFETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_vpa && cpu_vda && cpu_rwb) |-> cpu_dout == mem_din); // R1
  AST_FEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cpu_dout ^ mem_din) <= 2); // R6
  AST_SIG_AFTER_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> $past(cpu_vpa && !cpu_vda)); // R3
  AST_SIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |=> !sig_valid); // R3
  AST_TRIG_FROM_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |-> $past(cpu_vpa && cpu_vda && mode_sel == 2'd2 && mem_din == 8'hDB)); // R4
  AST_BE_NEEDS_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(be_out) |-> $past(!cpu_rdy)); // R5
  AST_LPTR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lptr_valid |-> $past(cpu_vda && !cpu_vpa && cpu_rwb)); // R7
  AST_LPTR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    lptr_valid |=> !lptr_valid); // R7
endmodule

bind opcode_rewriter opcode_rewriter_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mem_din(mem_din),
  .cpu_dout(cpu_dout), .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda), .cpu_rwb(cpu_rwb),
  .cpu_rdy(cpu_rdy), .be_out(be_out), .sig_valid(sig_valid),
  .trig_valid(trig_valid), .lptr_valid(lptr_valid)
);

// File: tb/tb_opcode_rewriter.sv
`timescale 1ns/1ps
module tb_opcode_rewriter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic [7:0]  mem_din = 8'h00;
  logic [7:0]  cpu_dout;
  logic [23:0] cpu_addr = 24'h0;
  logic        cpu_vpa = 1'b0, cpu_vda = 1'b0, cpu_rwb = 1'b1, cpu_rdy = 1'b1;
  logic        be_out, sig_valid, trig_valid, lptr_valid;
  logic [7:0]  sig_byte, lptr_data;
  logic [23:0] lptr_ptr, lptr_addr;
  logic [7:0]  seen_dout;
  int          n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  opcode_rewriter dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mem_din(mem_din),
    .cpu_dout(cpu_dout), .cpu_addr(cpu_addr), .cpu_vpa(cpu_vpa), .cpu_vda(cpu_vda),
    .cpu_rwb(cpu_rwb), .cpu_rdy(cpu_rdy), .be_out(be_out), .sig_valid(sig_valid),
    .sig_byte(sig_byte), .trig_valid(trig_valid), .lptr_valid(lptr_valid),
    .lptr_ptr(lptr_ptr), .lptr_addr(lptr_addr), .lptr_data(lptr_data)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic vpa, input logic vda, input logic rwb,
                     input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_vpa = vpa; cpu_vda = vda; cpu_rwb = rwb; cpu_addr = a; mem_din = d;
    #0.5;
    seen_dout = cpu_dout;
    @(posedge clk);
    #0.5;
  endtask

  function automatic logic [7:0] expect_fetch(input logic [1:0] m, input logic [7:0] b);
    if (m == 2'd1 && b == 8'h02) return b + 8'h40;
    if (m == 2'd2 && b == 8'hDB) return b - 8'h10;
    if (m == 2'd3 && (b == 8'hDB || b == 8'hCB)) return b - 8'h04;
    return b;
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #0.5;
    chk("R10 be_out", be_out, 1);
    chk("R10 valids", {sig_valid, trig_valid, lptr_valid}, 0);
    chk("R10 fields", {sig_byte, lptr_data, lptr_ptr, lptr_addr}, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int m = 0; m < 4; m++) begin
      mode_sel = m[1:0];
      for (int b = 0; b < 256; b++) begin
        cyc(1, 1, 1, 24'h001000, b[7:0]);
        chk((m == 1) ? "R2 fetch" : (m == 2) ? "R4 fetch" : (m == 3) ? "R6 fetch" : "R2 pass",
            seen_dout, expect_fetch(m[1:0], b[7:0]));
        cyc(1, 0, 1, 24'h001001, b[7:0]); chk("R1 operand", seen_dout, b);
        cyc(0, 1, 1, 24'h002000, b[7:0]); chk("R1 data", seen_dout, b);
        cyc(1, 1, 0, 24'h002001, b[7:0]); chk("R1 write", seen_dout, b);
      end
    end

    mode_sel = 2'd1;
    cyc(1, 1, 1, 24'h0, 8'h02);
    cyc(1, 0, 1, 24'h1, 8'h5A);
    chk("R3 sig_valid", sig_valid, 1); chk("R3 sig_byte", sig_byte, 8'h5A);
    cyc(0, 0, 1, 24'h2, 8'h00);
    chk("R3 pulse one cycle", sig_valid, 0);
    cyc(1, 1, 1, 24'h0, 8'h02);
    cyc(0, 1, 1, 24'h1, 8'h77);
    chk("R3 abandon", sig_valid, 0); chk("R3 byte kept", sig_byte, 8'h5A);
    cyc(1, 1, 1, 24'h0, 8'h02);
    cyc(1, 1, 1, 24'h1, 8'hEA);
    cyc(1, 0, 1, 24'h2, 8'h33);
    chk("R9 restart idle", sig_valid, 0);
    cyc(1, 1, 1, 24'h0, 8'h02);
    cyc(1, 1, 1, 24'h1, 8'h02);
    cyc(1, 0, 1, 24'h2, 8'h66);
    chk("R9 restart new", sig_byte, 8'h66);

    mode_sel = 2'd2;
    cyc(1, 1, 1, 24'h10, 8'hDB);
    chk("R4 trig", trig_valid, 1);
    cyc(1, 0, 1, 24'h11, 8'h00);
    chk("R4 trig pulse", trig_valid, 0);
    cyc(0, 0, 1, 24'h11, 8'h00);
    chk("R5 no early take", be_out, 1);
    cpu_rdy = 1'b0;
    cyc(0, 0, 1, 24'h11, 8'h00);
    chk("R5 take", be_out, 0);
    cyc(0, 0, 1, 24'h11, 8'h00);
    chk("R5 hold", be_out, 0);
    cpu_rdy = 1'b1;
    cyc(0, 0, 1, 24'h11, 8'h00);
    chk("R5 release", be_out, 1);
    cyc(1, 1, 1, 24'h10, 8'hDB);
    cyc(1, 1, 1, 24'h11, 8'hEA);
    cpu_rdy = 1'b0;
    cyc(0, 0, 1, 24'h12, 8'h00);
    chk("R5 cancel", be_out, 1);
    cpu_rdy = 1'b1;

    mode_sel = 2'd3;
    cyc(1, 1, 1, 24'h20, 8'hCB);
    cyc(1, 0, 1, 24'h21, 8'h40);
    cyc(0, 0, 1, 24'h21, 8'h00);
    cyc(0, 1, 1, 24'h40, 8'h34);
    cyc(0, 1, 1, 24'h41, 8'h12);
    cyc(0, 1, 1, 24'h42, 8'h7E);
    chk("R7 not yet", lptr_valid, 0);
    cyc(0, 1, 1, 24'h7E1234, 8'h99);
    chk("R7 valid", lptr_valid, 1);
    chk("R7 ptr", lptr_ptr, 24'h7E1234);
    chk("R7 addr", lptr_addr, 24'h7E1234);
    chk("R7 data", lptr_data, 8'h99);
    cyc(1, 1, 1, 24'h22, 8'hDB);
    cyc(1, 0, 1, 24'h23, 8'h50);
    cyc(0, 1, 1, 24'h50, 8'h00);
    cyc(0, 1, 1, 24'h51, 8'h20);
    cyc(0, 0, 1, 24'h51, 8'h00);
    cyc(0, 1, 1, 24'h52, 8'h01);
    cyc(0, 1, 1, 24'h012000, 8'hAA);
    chk("R8 abandon", lptr_valid, 0);
    chk("R8 data kept", lptr_data, 8'h99);
    cyc(1, 1, 1, 24'h24, 8'hDB);
    cyc(0, 1, 1, 24'h60, 8'h10);
    cyc(0, 1, 1, 24'h61, 8'h20);
    cyc(0, 1, 1, 24'h62, 8'h03);
    cyc(0, 1, 1, 24'h032015, 8'h5C);
    chk("R7 y-index addr", lptr_addr, 24'h032015);
    chk("R7 y-index ptr", lptr_ptr, 24'h032010);

    report();
  end
endmodule